// File: doc/BRIEF.md
# Configurable Format Serial Receiver

This block recovers asynchronous serial frames from an idle-high receive line. It runs from a free-running system clock and is paced by a one-cycle oversampling strobe that the surrounding logic raises at sixteen times the bit rate. A falling line marks a candidate start bit. The receiver confirms that bit at its centre and then samples every following bit at its centre.

The frame layout follows a set of static configuration inputs. These choose the data width (five to eight bits), an optional trailing bit used either as a checked parity bit or as a captured extra bit, the parity rule, and a stop-length selector. The receiver reads that selector but does not act on it, because only the first stop bit is checked. An address-filter mode lets a node on a shared line skip ordinary data frames and react only to frames whose extra bit is set.

For each accepted frame the receiver raises a one-cycle valid strobe. In the same cycle it presents the right-aligned data, the extra bit, and parity and framing error flags. All of these are held until the next accepted frame.

Top module: `uart_frame_rx`

## Requirements
- R1: A low level on an idle line starts a frame only if the line still reads low half a bit time later (8 oversampling ticks). If the line is high at that point, no frame is delivered and the receiver returns to waiting for a start.
- R2: Data bits arrive least-significant first. `cfg_len` selects the width: 0 means 5 bits, 1 means 6, 2 means 7 and 3 means 8. `rx_data` is right-aligned, with every bit above the selected width equal to 0.
- R3: When `cfg_par_en` is 1, the bit after the data is checked against `cfg_par_type`. The encodings are: 0 odd (data plus parity holds an odd number of ones), 1 even, 2 mark (bit must be 1), 3 space (bit must be 0). `rx_perr` is 1 exactly when the check fails. With parity off, `rx_perr` is 0.
- R4: When `cfg_xb_en` is 1 and `cfg_par_en` is 0, the bit after the data is reported on `rx_xbit`. In every other configuration `rx_xbit` is 0, and parity takes precedence over the extra bit.
- R5: When `cfg_mp_en` is 1, a frame is delivered only if its reported extra bit is 1. Other frames produce no valid strobe and leave all outputs unchanged.
- R6: The first stop bit must read high. If it reads low, `rx_ferr` is 1, and the data is still delivered with the valid strobe.
- R7: After a low stop bit, the receiver starts no new frame until the line has returned high.
- R8: `cfg_stop_long` has no effect on reception. A new frame whose start bit directly follows a single stop bit is received correctly in either setting.
- R9: `rx_valid` is a one-cycle strobe. `rx_data`, `rx_xbit`, `rx_perr` and `rx_ferr` change only in the cycle `rx_valid` is 1, and otherwise hold their values.
- R10: After reset, `rx_valid`, `rx_data`, `rx_xbit`, `rx_perr` and `rx_ferr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling strobe, one cycle wide, at OVS times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_len | input | 2 | Data width code, 0..3 for 5..8 bits |
| cfg_par_en | input | 1 | Parity check enable |
| cfg_par_type | input | 2 | Parity rule: 0 odd, 1 even, 2 mark, 3 space |
| cfg_xb_en | input | 1 | Extra bit enable, used only when parity is off |
| cfg_stop_long | input | 1 | Stop length selector, not acted on by the receiver |
| cfg_mp_en | input | 1 | Address-filter mode enable |
| rx_data | output | 8 | Received data, right-aligned |
| rx_xbit | output | 1 | Received extra bit |
| rx_valid | output | 1 | One-cycle strobe for a delivered frame |
| rx_perr | output | 1 | Parity mismatch flag for the last delivered frame |
| rx_ferr | output | 1 | Low first stop bit flag for the last delivered frame |

## Verification
The bench uses the default OVS of 16 and a two-flop input synchronizer, with a strobe every fourth clock. A bit therefore lasts 64 clocks, and the synchronizer delay stays well inside the distance from an edge to a bit centre. This setting covers all four widths, correct and corrupted bits under each parity rule, and extra-bit frames with and without address filtering. It also covers a low stop bit followed by a long low stretch, a short start glitch, and starts that arrive with no idle gap after a single stop bit.

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic [1:0] cfg_par_type,
  input  logic       cfg_xb_en,
  input  logic       cfg_stop_long,
  input  logic       cfg_mp_en,
  output logic [7:0] rx_data,
  output logic       rx_xbit,
  output logic       rx_valid,
  output logic       rx_perr,
  output logic       rx_ferr
);
  localparam int CW = $clog2(OVS);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_TAIL, S_STOP, S_HOLD} st_t;

  st_t             st;
  logic [SYNC-1:0] sync_q;
  logic [CW-1:0]   cnt;
  logic [2:0]      idx;
  logic [7:0]      sh;
  logic            tail;
  logic            rx_s, at_mid, at_half, tail_on, xb_val, par_exp, deliver;
  logic [2:0]      last_idx;

  assign rx_s     = sync_q[SYNC-1];
  assign at_mid   = (cnt == CW'(OVS - 1));
  assign at_half  = (cnt == CW'(OVS / 2 - 1));
  assign last_idx = {1'b1, cfg_len};
  assign tail_on  = cfg_par_en | cfg_xb_en;
  assign xb_val   = cfg_xb_en & ~cfg_par_en & tail;
  assign deliver  = ~cfg_mp_en | xb_val;

  always_comb begin
    case (cfg_par_type)
      2'd0:    par_exp = ~^sh;
      2'd1:    par_exp = ^sh;
      2'd2:    par_exp = 1'b1;
      default: par_exp = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      idx      <= '0;
      sh       <= '0;
      tail     <= 1'b0;
      rx_data  <= '0;
      rx_xbit  <= 1'b0;
      rx_valid <= 1'b0;
      rx_perr  <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: if (!rx_s) begin
            st  <= S_START;
            cnt <= '0;
          end
          S_START: begin
            if (at_half) begin
              cnt <= '0;
              if (rx_s) st <= S_IDLE;
              else begin
                st   <= S_DATA;
                idx  <= '0;
                sh   <= '0;
                tail <= 1'b0;
              end
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            if (at_mid) begin
              cnt     <= '0;
              sh[idx] <= rx_s;
              if (idx == last_idx) st <= tail_on ? S_TAIL : S_STOP;
              else                 idx <= idx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          S_TAIL: begin
            if (at_mid) begin
              cnt  <= '0;
              tail <= rx_s;
              st   <= S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (at_mid) begin
              cnt <= '0;
              if (deliver) begin
                rx_valid <= 1'b1;
                rx_data  <= sh;
                rx_xbit  <= xb_val;
                rx_perr  <= cfg_par_en & (tail != par_exp);
                rx_ferr  <= ~rx_s;
              end
              st <= rx_s ? S_IDLE : S_HOLD;
            end else cnt <= cnt + 1'b1;
          end
          S_HOLD: if (rx_s) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module uart_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_len,
  input logic       cfg_par_en,
  input logic       cfg_mp_en,
  input logic [7:0] rx_data,
  input logic       rx_xbit,
  input logic       rx_valid,
  input logic       rx_perr,
  input logic       rx_ferr
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable({rx_data, rx_xbit, rx_perr, rx_ferr})); // R9
  AST_UPPER_ZERO5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_len == 2'd0) |-> rx_data[7:5] == 3'd0); // R2
  AST_UPPER_ZERO7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_len == 2'd2) |-> !rx_data[7]); // R2
  AST_NO_PERR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_par_en) |-> !rx_perr); // R3
  AST_XBIT_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_par_en) |-> !rx_xbit); // R4
  AST_MP_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_mp_en) |-> rx_xbit); // R5
endmodule

bind uart_frame_rx uart_frame_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
  .cfg_mp_en(cfg_mp_en), .rx_data(rx_data), .rx_xbit(rx_xbit),
  .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
);

// File: tb/uart_frame_rx_tb.sv
module uart_frame_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int BT         = 16 * TDIV;

  logic       clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3, cfg_par_type = 2'd0;
  logic       cfg_par_en = 0, cfg_xb_en = 0, cfg_stop_long = 0, cfg_mp_en = 0;
  logic [7:0] rx_data;
  logic       rx_xbit, rx_valid, rx_perr, rx_ferr, tick;
  int         tcnt = 0;
  int         checks = 0, fails = 0;
  logic [7:0] last_data = 8'h00;

  typedef struct { logic [7:0] d; logic x; logic p; logic f; string tag; } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
  assign tick = (tcnt == 0);

  uart_frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_type(cfg_par_type), .cfg_xb_en(cfg_xb_en),
    .cfg_stop_long(cfg_stop_long), .cfg_mp_en(cfg_mp_en), .rx_data(rx_data),
    .rx_xbit(rx_xbit), .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
  );

  always @(negedge clk) if (rst_n && rx_valid) begin
    checks++;
    if (q.size() == 0) begin
      fails++;
      $display("FAIL unexpected frame (R5/R7/R1): got data=%h, expected none", rx_data);
    end else begin
      exp_t e;
      e = q.pop_front();
      if (rx_data !== e.d || rx_xbit !== e.x || rx_perr !== e.p || rx_ferr !== e.f) begin
        fails++;
        $display("FAIL %s: got d=%h x=%b p=%b f=%b, expected d=%h x=%b p=%b f=%b",
                 e.tag, rx_data, rx_xbit, rx_perr, rx_ferr, e.d, e.x, e.p, e.f);
      end
      last_data = e.d;
    end
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h, expected %h", tag, got, exp);
    end
  endtask

  task automatic bits(input logic v, input int n);
    rxd = v;
    repeat (n * BT) @(negedge clk);
  endtask

  function automatic logic [7:0] msk(input logic [7:0] d);
    return d & (8'hFF >> (3 - cfg_len));
  endfunction

  function automatic logic par_of(input logic [7:0] d, input logic [1:0] t);
    case (t)
      2'd0: return ~^msk(d);
      2'd1: return ^msk(d);
      2'd2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic send(input logic [7:0] d, input logic tl, input logic stopb, input logic push,
                      input logic ex, input logic ep, input int gap, input string tag);
    exp_t e;
    if (push) begin
      e.d = msk(d); e.x = ex; e.p = ep; e.f = ~stopb; e.tag = tag;
      q.push_back(e);
    end
    bits(1'b0, 1);
    for (int i = 0; i < 5 + cfg_len; i++) bits(d[i], 1);
    if (cfg_par_en || cfg_xb_en) bits(tl, 1);
    bits(stopb, 1);
    if (!stopb) bits(1'b0, 4);
    rxd = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d frames missing, expected 0", tag, q.size());
      q.delete();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R10 reset data", rx_data, 8'h00);
    check("R10 reset flags", {4'd0, rx_valid, rx_xbit, rx_perr, rx_ferr}, 8'h00);
    rst_n = 1'b1;
    repeat (BT) @(negedge clk);

    for (int l = 0; l < 4; l++) begin
      cfg_len = 2'(l);
      send(8'hA5, 0, 1, 1, 0, 0, 2 * BT, "R2 width A5");
      send(8'hFF, 0, 1, 1, 0, 0, 2 * BT, "R2 width FF");
      send(8'h3C, 0, 1, 1, 0, 0, 2 * BT, "R2 width 3C");
    end
    drain("R2 drain");

    cfg_par_en = 1;
    for (int t = 0; t < 4; t++) begin
      cfg_par_type = 2'(t);
      for (int l = 1; l < 4; l += 2) begin
        cfg_len = 2'(l);
        send(8'h5B, par_of(8'h5B, 2'(t)), 1, 1, 0, 0, BT, "R3 parity good");
        send(8'h5B, ~par_of(8'h5B, 2'(t)), 1, 1, 0, 1, BT, "R3 parity bad");
        send(8'h80, par_of(8'h80, 2'(t)), 1, 1, 0, 0, BT, "R3 parity good 80");
      end
    end
    cfg_xb_en = 1;
    send(8'h12, 1, 1, 1, 0, 1, BT, "R4 parity wins over extra");
    drain("R3 drain");

    cfg_par_en = 0; cfg_len = 2'd3;
    send(8'hC3, 1, 1, 1, 1, 0, BT, "R4 extra one");
    send(8'hC4, 0, 1, 1, 0, 0, BT, "R4 extra zero");
    cfg_len = 2'd0;
    send(8'h0E, 1, 1, 1, 1, 0, BT, "R4 extra len5");
    drain("R4 drain");

    cfg_mp_en = 1; cfg_len = 2'd3;
    send(8'h41, 1, 1, 1, 1, 0, BT, "R5 address frame");
    drain("R5 address drain");
    send(8'h99, 0, 1, 0, 0, 0, BT, "R5 filtered");
    drain("R5 no strobe");
    check("R5 R9 held after filter", rx_data, 8'h41);
    send(8'h42, 1, 1, 1, 1, 0, BT, "R5 address frame 2");
    cfg_xb_en = 0;
    send(8'h77, 1, 1, 0, 0, 0, BT, "R5 filtered no extra");
    drain("R5 drain");
    check("R5 R9 held no extra", rx_data, 8'h42);
    cfg_mp_en = 0;

    send(8'h6D, 0, 0, 1, 0, 0, BT, "R6 low stop");
    send(8'h2E, 0, 1, 1, 0, 0, BT, "R7 after low stop");
    drain("R7 drain");
    check("R6 R9 ferr cleared by good frame", {7'd0, rx_ferr}, 8'h00);

    rxd = 1'b0; repeat (3 * TDIV) @(negedge clk); rxd = 1'b1;
    repeat (2 * BT) @(negedge clk);
    drain("R1 glitch dropped");
    send(8'hB7, 0, 1, 1, 0, 0, BT, "R1 after glitch");
    drain("R1 drain");

    for (int s = 0; s < 2; s++) begin
      cfg_stop_long = s[0];
      send(8'h11, 0, 1, 1, 0, 0, 0, "R8 back to back a");
      send(8'hEE, 0, 1, 1, 0, 0, 0, "R8 back to back b");
      send(8'h5A, 0, 1, 1, 0, 0, BT, "R8 back to back c");
    end
    drain("R8 drain");
    check("R9 last data held", rx_data, last_data);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule